// File: doc/BRIEF.md
# CAN Fault Confinement Monitor

This block sits beside a CAN protocol engine and turns its raw error information into something a host can act on. It looks at the transmit and receive error counters, the bus-off indication and the per-cycle interrupt causes raised by the engine. From these it keeps a two-bit fault confinement state and a vector of sticky event flags that the host reads and then clears by writing ones.

When the node goes bus-off, the monitor raises a request that the surrounding logic uses to put the node into listen-only operation. This keeps the receive error counter from moving while the host recovers. Arbitration loss is treated as a transmit failure, because transmissions are single-shot. Transmit outcomes are only recorded while a frame is still outstanding. When the host clears a transmit error, any transmit confirmation still pending is dropped along with it. The interrupt line is high while any flag is pending.

Top module: `can_fault_monitor`

## Requirements
- R1: `state_o` is 3 when `bus_off_i` is high. Otherwise it is 2 when either counter is at least 128, 1 when either counter is strictly greater than the warning limit, and 0 in all other cases. It reflects the inputs of the previous clock cycle.
- R2: The warning limit comes out of reset as 96. A cycle with `lim_we_i` high loads `lim_wdata_i`, which takes effect from the next cycle.
- R3: `cause_warn_i` with `bus_off_i` high sets event bit 0 (bus-off) and raises `listen_only_o`. `listen_only_o` stays high until the host clears bit 0 in a cycle where `bus_off_i` is low.
- R4: `cause_warn_i` with `bus_off_i` low and a counter above the limit sets event bit 1 (warning). Without a counter above the limit, nothing is set.
- R5: `cause_passive_i` sets event bit 2 (passive) only when either counter is at least 128.
- R6: `cause_bus_err_i` with `bus_err_rx_i`=1 sets event bit 4 (receive error). With `bus_err_rx_i`=0 it sets event bit 3 (transmit error).
- R7: `cause_arb_lost_i` sets event bit 7 (arbitration lost), and it also sets event bit 3.
- R8: Event bits 3 and 5 are only set while `tx_pending_i` is high. `cause_tx_done_i` sets bit 5 (transmit confirmation).
- R9: A host clear of bit 3 while bit 3 is set also clears bit 5. A clear of bit 3 while bit 3 is already clear leaves bit 5 alone.
- R10: `cause_rx_done_i` sets event bit 6 (receive indication). `cause_wake_i` sets event bit 8 (wake-up).
- R11: A set event bit stays set until a one is written to it on `ev_clr_i`. If a cause and a clear hit the same bit in the same cycle, the bit stays set.
- R12: `irq_o` is high exactly when at least one event bit is set.
- R13: After reset, events, state, `listen_only_o` and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tec_i | input | 8 | Transmit error counter |
| rec_i | input | 8 | Receive error counter |
| bus_off_i | input | 1 | Node is bus-off |
| cause_warn_i | input | 1 | Error/warning status changed |
| cause_passive_i | input | 1 | Error-passive status changed |
| cause_bus_err_i | input | 1 | Bus error captured |
| bus_err_rx_i | input | 1 | Bus error occurred while receiving |
| cause_arb_lost_i | input | 1 | Arbitration lost |
| cause_tx_done_i | input | 1 | Transmit buffer released |
| cause_rx_done_i | input | 1 | Frame received |
| cause_wake_i | input | 1 | Wake-up seen |
| tx_pending_i | input | 1 | A transmit frame is outstanding |
| lim_we_i | input | 1 | Warning limit write strobe |
| lim_wdata_i | input | 8 | New warning limit |
| ev_clr_i | input | 9 | Write-one-to-clear event mask |
| state_o | output | 2 | Fault confinement state code |
| events_o | output | 9 | Sticky event flags |
| listen_only_o | output | 1 | Request to force listen-only mode |
| irq_o | output | 1 | Interrupt, any event pending |

## Verification
The bench builds the block with its defaults: 8-bit counters, an initial limit of 96, a passive threshold of 128 and the registered state variant. These values put the limit boundary (96 against 97) and the passive boundary (127 against 128) within one table row each. A later write of 50 to the limit shows that the comparison really follows the register. An 8-bit counter also lets 255 stand in for a node that is about to go bus-off.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;

   typedef enum logic [1:0] {
      FS_ACTIVE  = 2'd0,
      FS_WARNING = 2'd1,
      FS_PASSIVE = 2'd2,
      FS_BUSOFF  = 2'd3
   } fault_state_e;

   // event bit positions, decoded by host software
   localparam int EV_BUSOFF  = 0;
   localparam int EV_WARN    = 1;
   localparam int EV_PASSIVE = 2;
   localparam int EV_TXERR   = 3;
   localparam int EV_RXERR   = 4;
   localparam int EV_TXCONF  = 5;
   localparam int EV_RXIND   = 6;
   localparam int EV_ARBLOST = 7;
   localparam int EV_WAKE    = 8;
   localparam int EV_COUNT   = 9;

   typedef struct packed {
      logic warn_chg;
      logic passive_chg;
      logic bus_err;
      logic bus_err_rx;
      logic arb_lost;
      logic tx_done;
      logic rx_done;
      logic wake;
   } cause_t;

endpackage

// File: rtl/can_fault_level.sv
module can_fault_level
   import can_fault_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int WARN_INIT   = 96,
   parameter int PASSIVE_LIM = 128,
   parameter bit REG_STATE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lim_we,
   input  logic [CNT_W-1:0] lim_wdata,
   input  logic [CNT_W-1:0] tec,
   input  logic [CNT_W-1:0] rec,
   input  logic             bus_off,
   output logic             over_warn,
   output logic             over_passive,
   output fault_state_e     state
);

   localparam logic [CNT_W-1:0] LIM_RST = CNT_W'(WARN_INIT);
   localparam logic [CNT_W-1:0] PASS_V  = CNT_W'(PASSIVE_LIM);

   initial begin
      assert (CNT_W >= 2) else $error("counter width too small");
      assert (WARN_INIT < (1 << CNT_W)) else $error("warning limit exceeds counter range");
      assert (PASSIVE_LIM < (1 << CNT_W)) else $error("passive limit exceeds counter range");
   end

   logic [CNT_W-1:0] lim_q;
   fault_state_e     st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lim_q <= LIM_RST;
      else if (lim_we) lim_q <= lim_wdata;
   end

   assign over_warn    = (tec > lim_q) || (rec > lim_q);
   assign over_passive = (tec >= PASS_V) || (rec >= PASS_V);

   always_comb begin
      if (bus_off)           st_d = FS_BUSOFF;
      else if (over_passive) st_d = FS_PASSIVE;
      else if (over_warn)    st_d = FS_WARNING;
      else                   st_d = FS_ACTIVE;
   end

   generate
      if (REG_STATE) begin : g_reg
         fault_state_e st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= FS_ACTIVE;
            else        st_q <= st_d;
         end
         assign state = st_q;

         AST_BUSOFF_STATE: assert property (@(posedge clk) disable iff (!rst_n)
            bus_off |=> state == FS_BUSOFF); // R1
         AST_PASSIVE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_off && (tec >= PASS_V)) |=> state == FS_PASSIVE); // R1
      end else begin : g_comb
         assign state = st_d;
      end
   endgenerate

   AST_LIMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      lim_we |=> lim_q == $past(lim_wdata)); // R2

endmodule

// File: rtl/can_fault_cause_map.sv
module can_fault_cause_map
   import can_fault_pkg::*;
(
   input  cause_t              cause,
   input  logic                bus_off,
   input  logic                over_warn,
   input  logic                over_passive,
   input  logic                tx_pending,
   output logic [EV_COUNT-1:0] set_vec
);

   logic tx_fail;

   // single-shot transmit: losing arbitration ends the attempt as a failure
   assign tx_fail = cause.arb_lost || (cause.bus_err && !cause.bus_err_rx);

   always_comb begin
      set_vec             = '0;
      set_vec[EV_BUSOFF]  = cause.warn_chg && bus_off;
      set_vec[EV_WARN]    = cause.warn_chg && !bus_off && over_warn;
      set_vec[EV_PASSIVE] = cause.passive_chg && over_passive;
      set_vec[EV_TXERR]   = tx_pending && tx_fail;
      set_vec[EV_RXERR]   = cause.bus_err && cause.bus_err_rx;
      set_vec[EV_TXCONF]  = tx_pending && cause.tx_done;
      set_vec[EV_RXIND]   = cause.rx_done;
      set_vec[EV_ARBLOST] = cause.arb_lost;
      set_vec[EV_WAKE]    = cause.wake;
   end

endmodule

// File: rtl/can_fault_events.sv
module can_fault_events #(
   parameter int N        = 9,
   parameter int LINK_SRC = 3,
   parameter int LINK_DST = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] ev_q
);

   initial begin
      assert (LINK_SRC < N && LINK_DST < N) else $error("link index out of range");
      assert (LINK_SRC != LINK_DST) else $error("link source equals destination");
   end

   logic [N-1:0] clr_eff;

   always_comb begin
      clr_eff           = clr_vec;
      clr_eff[LINK_DST] = clr_vec[LINK_DST] || (clr_vec[LINK_SRC] && ev_q[LINK_SRC]);
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set_vec[i] || (q && !clr_eff[i]);
         end
         assign ev_q[i] = q;
      end
   endgenerate

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(ev_q) & ~$past(clr_eff)) & ~ev_q) == '0); // R11
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> (ev_q & $past(set_vec)) == $past(set_vec)); // R11
   AST_TXCONF_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[LINK_SRC] && ev_q[LINK_SRC] && !set_vec[LINK_DST]) |=> !ev_q[LINK_DST]); // R9

endmodule

// File: rtl/can_fault_monitor.sv
module can_fault_monitor
   import can_fault_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int WARN_INIT   = 96,
   parameter int PASSIVE_LIM = 128,
   parameter bit REG_STATE   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CNT_W-1:0]    tec_i,
   input  logic [CNT_W-1:0]    rec_i,
   input  logic                bus_off_i,
   input  logic                cause_warn_i,
   input  logic                cause_passive_i,
   input  logic                cause_bus_err_i,
   input  logic                bus_err_rx_i,
   input  logic                cause_arb_lost_i,
   input  logic                cause_tx_done_i,
   input  logic                cause_rx_done_i,
   input  logic                cause_wake_i,
   input  logic                tx_pending_i,
   input  logic                lim_we_i,
   input  logic [CNT_W-1:0]    lim_wdata_i,
   input  logic [EV_COUNT-1:0] ev_clr_i,
   output logic [1:0]          state_o,
   output logic [EV_COUNT-1:0] events_o,
   output logic                listen_only_o,
   output logic                irq_o
);

   cause_t              cause;
   logic                over_warn;
   logic                over_passive;
   fault_state_e        state;
   logic [EV_COUNT-1:0] set_vec;
   logic                listen_q;

   assign cause = '{warn_chg:    cause_warn_i,
                    passive_chg: cause_passive_i,
                    bus_err:     cause_bus_err_i,
                    bus_err_rx:  bus_err_rx_i,
                    arb_lost:    cause_arb_lost_i,
                    tx_done:     cause_tx_done_i,
                    rx_done:     cause_rx_done_i,
                    wake:        cause_wake_i};

   can_fault_level #(
      .CNT_W(CNT_W), .WARN_INIT(WARN_INIT),
      .PASSIVE_LIM(PASSIVE_LIM), .REG_STATE(REG_STATE)
   ) u_level (
      .clk(clk), .rst_n(rst_n),
      .lim_we(lim_we_i), .lim_wdata(lim_wdata_i),
      .tec(tec_i), .rec(rec_i), .bus_off(bus_off_i),
      .over_warn(over_warn), .over_passive(over_passive),
      .state(state)
   );

   can_fault_cause_map u_map (
      .cause(cause), .bus_off(bus_off_i),
      .over_warn(over_warn), .over_passive(over_passive),
      .tx_pending(tx_pending_i), .set_vec(set_vec)
   );

   can_fault_events #(
      .N(EV_COUNT), .LINK_SRC(EV_TXERR), .LINK_DST(EV_TXCONF)
   ) u_events (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_vec), .clr_vec(ev_clr_i), .ev_q(events_o)
   );

   // bus-off parks the node in listen-only so the receive counter freezes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    listen_q <= 1'b0;
      else if (set_vec[EV_BUSOFF])                   listen_q <= 1'b1;
      else if (ev_clr_i[EV_BUSOFF] && !bus_off_i)    listen_q <= 1'b0;
   end

   assign listen_only_o = listen_q;
   assign state_o       = state;
   assign irq_o         = |events_o;

   AST_BUSOFF_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_warn_i && bus_off_i) |=> (listen_only_o && events_o[EV_BUSOFF])); // R3
   AST_LISTEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (listen_only_o && bus_off_i) |=> listen_only_o); // R3
   AST_ARB_TXERR: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_arb_lost_i && tx_pending_i) |=> (events_o[EV_TXERR] && events_o[EV_ARBLOST])); // R7
   AST_RXERR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_bus_err_i && bus_err_rx_i) |=> events_o[EV_RXERR]); // R6
   AST_TX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_pending_i && !events_o[EV_TXERR]) |=> !events_o[EV_TXERR]); // R8

endmodule

// File: tb/can_fault_monitor_test.sv
`timescale 1ns/1ps
module can_fault_monitor_test;

   // cause code bits: 0 warn, 1 passive, 2 bus err, 3 rx direction,
   // 4 arb lost, 5 tx done, 6 rx done, 7 wake
   typedef struct packed {
      logic [7:0] tec;
      logic [7:0] rec;
      logic       boff;
      logic [7:0] cause;
      logic       txp;
      logic [8:0] clr;
      logic [1:0] st;
      logic [8:0] ev;
      logic       req;
   } row_t;

   localparam int NROWS = 24;
   localparam row_t TBL [NROWS] = '{
      '{8'd0,   8'd0,   1'b0, 8'h00, 1'b0, 9'h000, 2'd0, 9'h000, 1'b0},
      '{8'd97,  8'd0,   1'b0, 8'h01, 1'b0, 9'h000, 2'd1, 9'h002, 1'b0},
      '{8'd96,  8'd96,  1'b0, 8'h01, 1'b0, 9'h002, 2'd0, 9'h000, 1'b0},
      '{8'd0,   8'd128, 1'b0, 8'h02, 1'b0, 9'h000, 2'd2, 9'h004, 1'b0},
      '{8'd127, 8'd127, 1'b0, 8'h02, 1'b0, 9'h004, 2'd1, 9'h000, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h0C, 1'b0, 9'h000, 2'd0, 9'h010, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h04, 1'b1, 9'h000, 2'd0, 9'h018, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h04, 1'b0, 9'h018, 2'd0, 9'h000, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h20, 1'b1, 9'h000, 2'd0, 9'h020, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h10, 1'b1, 9'h000, 2'd0, 9'h0A8, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h00, 1'b1, 9'h008, 2'd0, 9'h080, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h20, 1'b0, 9'h080, 2'd0, 9'h000, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'hC0, 1'b0, 9'h000, 2'd0, 9'h140, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h40, 1'b0, 9'h040, 2'd0, 9'h140, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h00, 1'b0, 9'h140, 2'd0, 9'h000, 1'b0},
      '{8'd255, 8'd0,   1'b1, 8'h01, 1'b0, 9'h000, 2'd3, 9'h001, 1'b1},
      '{8'd255, 8'd0,   1'b1, 8'h00, 1'b0, 9'h001, 2'd3, 9'h000, 1'b1},
      '{8'd0,   8'd0,   1'b0, 8'h00, 1'b0, 9'h000, 2'd0, 9'h000, 1'b1},
      '{8'd0,   8'd0,   1'b0, 8'h00, 1'b0, 9'h001, 2'd0, 9'h000, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h20, 1'b1, 9'h000, 2'd0, 9'h020, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h00, 1'b1, 9'h008, 2'd0, 9'h020, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h00, 1'b0, 9'h020, 2'd0, 9'h000, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h10, 1'b0, 9'h000, 2'd0, 9'h080, 1'b0},
      '{8'd0,   8'd0,   1'b0, 8'h00, 1'b0, 9'h080, 2'd0, 9'h000, 1'b0}
   };

   // requirement exercised by each row (row 2 also covers the R2 reset limit)
   localparam string TAGS [NROWS] = '{
      "R13", "R4", "R4", "R5", "R5", "R6", "R6", "R8",
      "R8", "R7", "R9", "R8", "R10", "R11", "R11", "R3",
      "R3", "R3", "R3", "R8", "R9", "R11", "R7", "R11"
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] tec_i, rec_i, lim_wdata_i;
   logic       bus_off_i, cause_warn_i, cause_passive_i, cause_bus_err_i;
   logic       bus_err_rx_i, cause_arb_lost_i, cause_tx_done_i, cause_rx_done_i;
   logic       cause_wake_i, tx_pending_i, lim_we_i;
   logic [8:0] ev_clr_i;
   logic [1:0] state_o;
   logic [8:0] events_o;
   logic       listen_only_o, irq_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   can_fault_monitor uut (
      .clk(clk), .rst_n(rst_n), .tec_i(tec_i), .rec_i(rec_i),
      .bus_off_i(bus_off_i), .cause_warn_i(cause_warn_i),
      .cause_passive_i(cause_passive_i), .cause_bus_err_i(cause_bus_err_i),
      .bus_err_rx_i(bus_err_rx_i), .cause_arb_lost_i(cause_arb_lost_i),
      .cause_tx_done_i(cause_tx_done_i), .cause_rx_done_i(cause_rx_done_i),
      .cause_wake_i(cause_wake_i), .tx_pending_i(tx_pending_i),
      .lim_we_i(lim_we_i), .lim_wdata_i(lim_wdata_i), .ev_clr_i(ev_clr_i),
      .state_o(state_o), .events_o(events_o),
      .listen_only_o(listen_only_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] tec, input logic [7:0] rec,
                        input logic boff, input logic [7:0] cause,
                        input logic txp, input logic [8:0] clr);
      tec_i            = tec;
      rec_i            = rec;
      bus_off_i        = boff;
      cause_warn_i     = cause[0];
      cause_passive_i  = cause[1];
      cause_bus_err_i  = cause[2];
      bus_err_rx_i     = cause[3];
      cause_arb_lost_i = cause[4];
      cause_tx_done_i  = cause[5];
      cause_rx_done_i  = cause[6];
      cause_wake_i     = cause[7];
      tx_pending_i     = txp;
      ev_clr_i         = clr;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      lim_we_i = 1'b0;
      lim_wdata_i = 8'd0;
      drive(8'd0, 8'd0, 1'b0, 8'h00, 1'b0, 9'h000);
      repeat (3) @(negedge clk);
      // R13: outputs held low in reset
      chk("R13", "state in reset", 16'(state_o), 16'd0);
      chk("R13", "events in reset", 16'(events_o), 16'd0);
      chk("R13", "listen in reset", 16'(listen_only_o), 16'd0);
      chk("R13", "irq in reset", 16'(irq_o), 16'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NROWS; i++) begin
         drive(TBL[i].tec, TBL[i].rec, TBL[i].boff, TBL[i].cause, TBL[i].txp, TBL[i].clr);
         @(negedge clk);
         chk("R1", $sformatf("state row %0d", i), 16'(state_o), 16'(TBL[i].st));
         chk(TAGS[i], $sformatf("events row %0d", i), 16'(events_o), 16'(TBL[i].ev));
         chk("R3", $sformatf("listen row %0d", i), 16'(listen_only_o), 16'(TBL[i].req));
         chk("R12", $sformatf("irq row %0d", i), 16'(irq_o), 16'(TBL[i].ev != 9'h000));
      end

      // R2: reprogram the limit to 50
      drive(8'd0, 8'd0, 1'b0, 8'h00, 1'b0, 9'h000);
      lim_we_i = 1'b1;
      lim_wdata_i = 8'd50;
      @(negedge clk);
      lim_we_i = 1'b0;
      drive(8'd51, 8'd0, 1'b0, 8'h01, 1'b0, 9'h000);
      @(negedge clk);
      chk("R2", "state above new limit", 16'(state_o), 16'd1);
      chk("R2", "warning above new limit", 16'(events_o), 16'h002);
      drive(8'd0, 8'd50, 1'b0, 8'h01, 1'b0, 9'h002);
      @(negedge clk);
      chk("R2", "state at new limit", 16'(state_o), 16'd0);
      chk("R2", "no warning at new limit", 16'(events_o), 16'h000);

      // R13: reset mid-run wipes pending flags and the listen request
      drive(8'd200, 8'd0, 1'b1, 8'h41, 1'b0, 9'h000);
      @(negedge clk);
      chk("R3", "bus-off before reset", 16'(events_o), 16'h041);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R13", "events after reset", 16'(events_o), 16'd0);
      chk("R13", "listen after reset", 16'(listen_only_o), 16'd0);
      chk("R13", "irq after reset", 16'(irq_o), 16'd0);
      rst_n = 1'b1;
      drive(8'd0, 8'd0, 1'b0, 8'h00, 1'b0, 9'h000);
      @(negedge clk);
      chk("R1", "state after reset", 16'(state_o), 16'd0);

      finish_run();
   end

endmodule